// File: doc/BRIEF.md
# Frame Setup Sequencer for a Palette-Based LCD Controller

This block prepares each frame for a panel controller that fetches its pixels by DMA. At each frame start it takes the first 16-bit word of the current buffer's palette area, the load mode, the panel size, the subpanel word and the bounds of two frame buffers. From these it works out the colour depth, where the pixel data begins, how many bytes one line takes, and which lines are shown. It then checks that the frame fits in the current buffer. A frame that does not fit raises a sync-error pulse and turns the controller off. A frame that fits ends with a done pulse for its buffer and, when double buffering is on, switches to the other buffer.

Enabling the controller is a write through `en_wr`/`en_val`. On that write the block checks every buffer address it will use against an inclusive address window. A bad address raises `addr_err` and leaves the controller off. Fetching memory is left to the surrounding DMA logic, which uses the outputs of this block.

Top module: `lcd_frame_setup`

## Requirements
- R1: The depth field is bits 14:12 of `pal_word`. Codes 1, 2 and 3 give `bpp` = 2, 4 and 8. Codes 4 to 7 give `bpp` = 16.
- R2: A frame whose depth code is 0 is skipped. It produces no `frame_valid`, no `buf_done` and no `sync_err`, and the current buffer stays the same.
- R3: `pix_base` is the current buffer's top address plus a header size. In load mode 2 the header is 0 bytes. In load modes 0 and 3 it is 512 bytes for depth codes 3 to 7 and 32 bytes for codes 1 and 2.
- R4: In load mode 1 a frame start has no effect: no pulse on any output, and the current buffer stays the same.
- R5: Let `need` = header + width*height*bpp/8, rounded down, where width = `width_m1`+1 and height = `height_m1`+1. When `need` is greater than (bottom − top + 2) of the current buffer, the block pulses `sync_err` for one cycle and clears `lcd_enabled`. When `need` equals that value, the frame is accepted.
- R6: An accepted frame pulses `buf_done` bit N for one cycle, where N is the buffer it used. `done_irq` pulses with it only when `done_irq_en` is 1.
- R7: After an accepted frame, the current buffer `cur_buf` toggles between 0 and 1 when `dual_mode` is 1, and stays the same when `dual_mode` is 0. A successful enable selects buffer 0.
- R8: When `subpanel` bit 31 is 0, `line_cnt` = height and `first_line` = 0. When bit 31 is 1 and bit 29 is 1, `first_line` = `subpanel`[25:16] and `line_cnt` = height. When bit 31 is 1 and bit 29 is 0, `line_cnt` = `subpanel`[25:16] and `first_line` = 0.
- R9: `stride` = width*bpp/8 bytes, rounded down.
- R10: Writing 1 through `en_wr` while disabled checks both addresses of buffer 0, and both addresses of buffer 1 as well when `dual_mode` is 1, against the window `win_lo` ≤ a ≤ `win_hi`. If all checked addresses pass, the controller is enabled. If any fails, `addr_err` pulses and the controller stays off. Writing 0 disables the controller.
- R11: After reset the controller is disabled with buffer 0 selected. A frame start is ignored while the controller is disabled. When a frame start is accepted, its results appear one edge after the edge that registers its stage-one data, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_wr | input | 1 | Enable write strobe |
| en_val | input | 1 | Enable value written |
| dual_mode | input | 1 | Double buffering on |
| done_irq_en | input | 1 | Allows `done_irq` |
| frame_start | input | 1 | Frame start pulse |
| pal_word | input | 16 | First palette word of the current buffer |
| load_mode | input | 2 | 0/3 palette+data, 1 palette only, 2 data only |
| width_m1 | input | LW | Panel width minus one |
| height_m1 | input | LW | Panel height minus one |
| subpanel | input | 32 | Subpanel control word |
| buf0_top | input | AW | Buffer 0 start address |
| buf0_bot | input | AW | Buffer 0 end address |
| buf1_top | input | AW | Buffer 1 start address |
| buf1_bot | input | AW | Buffer 1 end address |
| win_lo | input | AW | Lowest legal address |
| win_hi | input | AW | Highest legal address |
| lcd_enabled | output | 1 | Controller enabled |
| cur_buf | output | 1 | Current buffer |
| frame_valid | output | 1 | One-cycle pulse: frame accepted, data outputs valid |
| bpp | output | 5 | Bits per pixel |
| pix_base | output | AW | Start address of pixel data |
| stride | output | LW+3 | Bytes per line |
| line_cnt | output | LW+1 | Lines to show |
| first_line | output | LW | First line shown |
| buf_done | output | 2 | One-cycle done pulse per buffer |
| done_irq | output | 1 | Done interrupt pulse |
| sync_err | output | 1 | Frame did not fit the buffer |
| addr_err | output | 1 | Enable refused because of a bad buffer address |

## Verification
An enable write is registered on one rising edge. `addr_err` and `lcd_enabled` are therefore read on the next falling edge. A frame start passes through two register stages, so every frame result (`frame_valid`, `sync_err`, `buf_done`, `done_irq`, `cur_buf` and the data outputs) is due on the second rising edge after the frame start is sampled. The bench drives each stimulus on a falling edge and reads the outputs on the falling edge that follows the second rising edge. It also reads them on the falling edge between the two rising edges and expects the outputs to be quiet there. In this way a result that arrives one cycle early or one cycle late is reported as a failure.

// File: rtl/lcd_setup_pkg.sv
// Package: constants and types shared by the frame setup sequencer.
// Assumes: header sizes fit in 10 bits.
package lcd_setup_pkg;

    localparam int HDR_SHORT_B = 32;
    localparam int HDR_LONG_B  = 512;

    // Load mode encoding.
    typedef enum logic [1:0] {
        LM_BOTH = 2'd0,
        LM_PAL  = 2'd1,
        LM_DATA = 2'd2,
        LM_RSVD = 2'd3
    } lmode_e;

    // Result of decoding the palette header.
    typedef struct packed {
        logic       ok;
        logic [4:0] bpp;
        logic [9:0] hdr;
    } depth_info_t;

endpackage

// File: rtl/lcd_depth_decode.sv
// Module: decodes the depth field of the first palette word into bits per
// pixel and the size of the header that precedes the pixel data.
// Assumes: load mode 3 behaves like mode 0.
module lcd_depth_decode
    import lcd_setup_pkg::*;
(
    input  logic [15:0] pal_word,
    input  logic [1:0]  load_mode,
    output depth_info_t info
);

    logic [2:0] code;

    // Map the depth code and load mode onto bpp and header bytes.
    always_comb begin
        code    = pal_word[14:12];
        info.ok = (code != 3'd0);
        case (code)
            3'd1:    info.bpp = 5'd2;
            3'd2:    info.bpp = 5'd4;
            3'd3:    info.bpp = 5'd8;
            3'd0:    info.bpp = 5'd0;
            default: info.bpp = 5'd16;
        endcase
        if (load_mode == LM_DATA)
            info.hdr = 10'd0;
        else if (code >= 3'd3)
            info.hdr = 10'(HDR_LONG_B);
        else
            info.hdr = 10'(HDR_SHORT_B);
    end

endmodule

// File: rtl/lcd_addr_window.sv
// Module: checks N addresses against an inclusive window; an address whose
// mask bit is clear is not checked.
// Assumes: lo <= hi for any useful result.
module lcd_addr_window #(
    parameter int AW = 32,
    parameter int N  = 4
) (
    input  logic [N*AW-1:0] addrs,
    input  logic [N-1:0]    use_mask,
    input  logic [AW-1:0]   lo,
    input  logic [AW-1:0]   hi,
    output logic            all_ok
);

    logic [N-1:0] in_rng;

    // One comparator pair per address.
    for (genvar i = 0; i < N; i++) begin : g_chk
        logic [AW-1:0] a;
        assign a         = addrs[i*AW +: AW];
        assign in_rng[i] = !use_mask[i] || ((a >= lo) && (a <= hi));
    end

    // All checked addresses must be inside.
    assign all_ok = &in_rng;

endmodule

// File: rtl/lcd_view_select.sv
// Module: picks the line count and first line from the subpanel word.
// Assumes: LW <= 10, since the field sits at bits 25:16.
module lcd_view_select #(
    parameter int LW = 10
) (
    input  logic [31:0]   sub_word,
    input  logic [LW-1:0] height_m1,
    output logic [LW:0]   lines,
    output logic [LW-1:0] first
);

    localparam int SUB_ON  = 31;
    localparam int SUB_TOP = 29;
    localparam int SUB_LSB = 16;

    logic [LW-1:0] fld;
    logic [LW:0]   full_h;

    assign fld    = sub_word[SUB_LSB +: LW];
    assign full_h = {1'b0, height_m1} + (LW+1)'(1);

    // Choose between full height, a shifted start, or a shortened count.
    always_comb begin
        lines = full_h;
        first = '0;
        if (sub_word[SUB_ON]) begin
            if (sub_word[SUB_TOP])
                first = fld;
            else
                lines = {1'b0, fld};
        end
    end

endmodule

// File: rtl/lcd_frame_setup.sv
// Module: per-frame setup sequencer. Stage one decodes the header and
// registers geometry and buffer bounds; stage two checks frame size and
// issues the frame result, done pulses and buffer switch.
// Assumes: frame_start pulses are at least two cycles apart (a start that
// arrives while stage one is busy is dropped); inputs stay stable for the
// cycle after frame_start; an enable write blocks a frame start in the
// same cycle and drops a frame in stage one.
module lcd_frame_setup
    import lcd_setup_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_wr,
    input  logic          en_val,
    input  logic          dual_mode,
    input  logic          done_irq_en,
    input  logic          frame_start,
    input  logic [15:0]   pal_word,
    input  logic [1:0]    load_mode,
    input  logic [LW-1:0] width_m1,
    input  logic [LW-1:0] height_m1,
    input  logic [31:0]   subpanel,
    input  logic [AW-1:0] buf0_top,
    input  logic [AW-1:0] buf0_bot,
    input  logic [AW-1:0] buf1_top,
    input  logic [AW-1:0] buf1_bot,
    input  logic [AW-1:0] win_lo,
    input  logic [AW-1:0] win_hi,
    output logic          lcd_enabled,
    output logic          cur_buf,
    output logic          frame_valid,
    output logic [4:0]    bpp,
    output logic [AW-1:0] pix_base,
    output logic [LW+2:0] stride,
    output logic [LW:0]   line_cnt,
    output logic [LW-1:0] first_line,
    output logic [1:0]    buf_done,
    output logic          done_irq,
    output logic          sync_err,
    output logic          addr_err
);

    localparam int WW  = LW + 1;
    localparam int PW  = 2 * WW;
    localparam int BW  = PW + 5;
    localparam int SW  = AW + 2;
    localparam int STW = LW + 3;
    localparam int NA  = 4;

    depth_info_t   dinfo;
    logic          win_ok;
    logic [LW:0]   view_lines;
    logic [LW-1:0] view_first;
    logic [WW-1:0] w_px;
    logic [WW-1:0] h_px;
    logic [PW-1:0] area_c;
    logic [WW+4:0] wbits_c;
    logic [STW-1:0] stride_c;
    logic          accept;

    logic          s1_vld;
    logic [4:0]    s1_bpp;
    logic [9:0]    s1_hdr;
    logic [PW-1:0] s1_area;
    logic [STW-1:0] s1_stride;
    logic [LW:0]   s1_lines;
    logic [LW-1:0] s1_first;
    logic [AW-1:0] s1_top;
    logic [AW-1:0] s1_bot;
    logic          s1_buf;

    logic [BW-1:0] s1_bits;
    logic [SW-1:0] need;
    logic [SW-1:0] avail;
    logic          too_big;

    lcd_depth_decode u_dec (
        .pal_word  (pal_word),
        .load_mode (load_mode),
        .info      (dinfo)
    );

    lcd_addr_window #(.AW(AW), .N(NA)) u_win (
        .addrs    ({buf1_bot, buf1_top, buf0_bot, buf0_top}),
        .use_mask ({dual_mode, dual_mode, 2'b11}),
        .lo       (win_lo),
        .hi       (win_hi),
        .all_ok   (win_ok)
    );

    lcd_view_select #(.LW(LW)) u_view (
        .sub_word  (subpanel),
        .height_m1 (height_m1),
        .lines     (view_lines),
        .first     (view_first)
    );

    // Panel geometry for stage one.
    assign w_px     = {1'b0, width_m1} + WW'(1);
    assign h_px     = {1'b0, height_m1} + WW'(1);
    assign area_c   = {{WW{1'b0}}, w_px} * {{WW{1'b0}}, h_px};
    assign wbits_c  = {5'b0, w_px} * {{WW{1'b0}}, dinfo.bpp};
    assign stride_c = wbits_c[WW+4:3];

    // Frame start is taken only when enabled, idle, not palette-only, and depth is known.
    assign accept = frame_start && !en_wr && lcd_enabled && !s1_vld &&
                    (load_mode != LM_PAL) && dinfo.ok;

    // Stage one data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_bpp    <= '0;
            s1_hdr    <= '0;
            s1_area   <= '0;
            s1_stride <= '0;
            s1_lines  <= '0;
            s1_first  <= '0;
            s1_top    <= '0;
            s1_bot    <= '0;
            s1_buf    <= 1'b0;
        end else if (accept) begin
            s1_bpp    <= dinfo.bpp;
            s1_hdr    <= dinfo.hdr;
            s1_area   <= area_c;
            s1_stride <= stride_c;
            s1_lines  <= view_lines;
            s1_first  <= view_first;
            s1_top    <= cur_buf ? buf1_top : buf0_top;
            s1_bot    <= cur_buf ? buf1_bot : buf0_bot;
            s1_buf    <= cur_buf;
        end
    end

    // Stage two size check: header plus pixel bytes against buffer span plus two.
    assign s1_bits = {{(BW-PW){1'b0}}, s1_area} * {{(BW-5){1'b0}}, s1_bpp};
    assign need    = {{(SW-10){1'b0}}, s1_hdr} + {{(SW-BW+3){1'b0}}, s1_bits[BW-1:3]};
    assign avail   = {2'b00, s1_bot} - {2'b00, s1_top} + {{(SW-2){1'b0}}, 2'b10};
    assign too_big = $signed(need) > $signed(avail);

    // Control: enable handling, stage valid, result pulses and buffer switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcd_enabled <= 1'b0;
            cur_buf     <= 1'b0;
            s1_vld      <= 1'b0;
            frame_valid <= 1'b0;
            buf_done    <= 2'b00;
            done_irq    <= 1'b0;
            sync_err    <= 1'b0;
            addr_err    <= 1'b0;
        end else begin
            frame_valid <= 1'b0;
            buf_done    <= 2'b00;
            done_irq    <= 1'b0;
            sync_err    <= 1'b0;
            addr_err    <= 1'b0;
            if (en_wr) begin
                s1_vld <= 1'b0;
                if (!en_val) begin
                    lcd_enabled <= 1'b0;
                end else if (!lcd_enabled) begin
                    if (win_ok) begin
                        lcd_enabled <= 1'b1;
                        cur_buf     <= 1'b0;
                    end else begin
                        addr_err <= 1'b1;
                    end
                end
            end else begin
                s1_vld <= accept;
                if (s1_vld) begin
                    if (too_big) begin
                        sync_err    <= 1'b1;
                        lcd_enabled <= 1'b0;
                    end else begin
                        frame_valid <= 1'b1;
                        buf_done    <= s1_buf ? 2'b10 : 2'b01;
                        done_irq    <= done_irq_en;
                        if (dual_mode)
                            cur_buf <= ~cur_buf;
                    end
                end
            end
        end
    end

    // Data outputs, loaded only for an accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bpp        <= '0;
            pix_base   <= '0;
            stride     <= '0;
            line_cnt   <= '0;
            first_line <= '0;
        end else if (!en_wr && s1_vld && !too_big) begin
            bpp        <= s1_bpp;
            pix_base   <= s1_top + {{(AW-10){1'b0}}, s1_hdr};
            stride     <= s1_stride;
            line_cnt   <= s1_lines;
            first_line <= s1_first;
        end
    end

endmodule

// File: rtl/lcd_frame_setup_chk.sv
// Module: property checker for the frame setup sequencer, bound to it below.
// Assumes: the clock and synchronous active-low reset of the checked block.
module lcd_frame_setup_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dual_mode,
    input logic       done_irq_en,
    input logic       lcd_enabled,
    input logic       cur_buf,
    input logic       frame_valid,
    input logic [4:0] bpp,
    input logic [1:0] buf_done,
    input logic       done_irq,
    input logic       sync_err,
    input logic       addr_err
);

    p_bpp_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (bpp == 5'd2 || bpp == 5'd4 || bpp == 5'd8 || bpp == 5'd16));

    p_sync_disables_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> !lcd_enabled);

    p_sync_no_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_err && frame_valid));

    p_done_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(buf_done));

    p_done_with_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_done != 2'b00) |-> frame_valid);

    p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (frame_valid && $past(done_irq_en)));

    p_toggle_dual_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && $past(dual_mode)) |-> (cur_buf != $past(cur_buf)));

    p_hold_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !$past(dual_mode)) |-> $stable(cur_buf));

    p_addr_err_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> !lcd_enabled);

    p_frame_when_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> lcd_enabled);

endmodule

bind lcd_frame_setup lcd_frame_setup_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dual_mode   (dual_mode),
    .done_irq_en (done_irq_en),
    .lcd_enabled (lcd_enabled),
    .cur_buf     (cur_buf),
    .frame_valid (frame_valid),
    .bpp         (bpp),
    .buf_done    (buf_done),
    .done_irq    (done_irq),
    .sync_err    (sync_err),
    .addr_err    (addr_err)
);

// File: tb/sim_lcd_frame_setup.sv
`timescale 1ns/1ps
module sim_lcd_frame_setup;

    localparam int AW = 32;
    localparam int LW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_wr = 1'b0;
    logic          en_val = 1'b0;
    logic          dual_mode = 1'b0;
    logic          done_irq_en = 1'b0;
    logic          frame_start = 1'b0;
    logic [15:0]   pal_word = '0;
    logic [1:0]    load_mode = '0;
    logic [LW-1:0] width_m1 = '0;
    logic [LW-1:0] height_m1 = '0;
    logic [31:0]   subpanel = '0;
    logic [AW-1:0] buf0_top = '0, buf0_bot = '0, buf1_top = '0, buf1_bot = '0;
    logic [AW-1:0] win_lo = '0, win_hi = '0;
    logic          lcd_enabled, cur_buf, frame_valid, done_irq, sync_err, addr_err;
    logic [4:0]    bpp;
    logic [AW-1:0] pix_base;
    logic [LW+2:0] stride;
    logic [LW:0]   line_cnt;
    logic [LW-1:0] first_line;
    logic [1:0]    buf_done;

    int checks = 0;
    int errors = 0;
    bit exp_en = 0;
    bit exp_buf = 0;

    always #2 clk = ~clk;

    lcd_frame_setup #(.AW(AW), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_val(en_val),
        .dual_mode(dual_mode), .done_irq_en(done_irq_en), .frame_start(frame_start),
        .pal_word(pal_word), .load_mode(load_mode), .width_m1(width_m1),
        .height_m1(height_m1), .subpanel(subpanel), .buf0_top(buf0_top),
        .buf0_bot(buf0_bot), .buf1_top(buf1_top), .buf1_bot(buf1_bot),
        .win_lo(win_lo), .win_hi(win_hi), .lcd_enabled(lcd_enabled),
        .cur_buf(cur_buf), .frame_valid(frame_valid), .bpp(bpp),
        .pix_base(pix_base), .stride(stride), .line_cnt(line_cnt),
        .first_line(first_line), .buf_done(buf_done), .done_irq(done_irq),
        .sync_err(sync_err), .addr_err(addr_err)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bpp_of(input int code);
        if (code == 1) return 2;
        if (code == 2) return 4;
        if (code == 3) return 8;
        return 16;
    endfunction

    function automatic int hdr_of(input int code, input int mode);
        if (mode == 2) return 0;
        return (code >= 3) ? 512 : 32;
    endfunction

    function automatic longint need_of(input int code, input int mode, input int wm1, input int hm1);
        return longint'(hdr_of(code, mode)) +
               (longint'(wm1 + 1) * longint'(hm1 + 1) * longint'(bpp_of(code))) / 8;
    endfunction

    function automatic bit in_win(input longint a);
        return (a >= longint'(win_lo)) && (a <= longint'(win_hi));
    endfunction

    task automatic do_enable(input bit v);
        bit exp_aerr;
        bit ok;
        exp_aerr = 0;
        @(negedge clk);
        en_wr = 1; en_val = v;
        @(negedge clk);
        en_wr = 0;
        if (v && !exp_en) begin
            ok = in_win(buf0_top) && in_win(buf0_bot) &&
                 (!dual_mode || (in_win(buf1_top) && in_win(buf1_bot)));
            if (ok) begin exp_en = 1; exp_buf = 0; end
            else exp_aerr = 1;
        end else if (!v) begin
            exp_en = 0;
        end
        chk("R10 addr_err", addr_err, exp_aerr);
        chk("R10 lcd_enabled", lcd_enabled, exp_en);
        chk("R7 cur_buf after enable", cur_buf, exp_buf);
    endtask

    task automatic run_frame(input int code, input int mode, input int wm1, input int hm1,
                             input logic [31:0] sp, input string tag);
        bit go, fit;
        longint need, avail, topv, botv;
        int h, f, lines, first;
        @(negedge clk);
        pal_word = {1'b1, 3'(code), 12'hA5C};
        load_mode = 2'(mode);
        width_m1 = LW'(wm1);
        height_m1 = LW'(hm1);
        subpanel = sp;
        frame_start = 1;
        @(negedge clk);
        frame_start = 0;
        chk("R11 no early result", {frame_valid, sync_err, buf_done}, 0);
        @(negedge clk);
        go = exp_en && (mode != 1) && (code != 0);
        topv = exp_buf ? longint'(buf1_top) : longint'(buf0_top);
        botv = exp_buf ? longint'(buf1_bot) : longint'(buf0_bot);
        need = need_of(code, mode, wm1, hm1);
        avail = botv - topv + 2;
        fit = go && (need <= avail);
        chk({tag, " frame_valid"}, frame_valid, fit);
        chk("R5 sync_err", sync_err, go && !fit);
        chk("R6 buf_done", buf_done, fit ? (exp_buf ? 2 : 1) : 0);
        chk("R6 done_irq", done_irq, fit && done_irq_en);
        if (go && !fit) exp_en = 0;
        chk("R5 lcd_enabled", lcd_enabled, exp_en);
        if (fit) begin
            h = hm1 + 1;
            f = int'(sp[25:16]);
            lines = h; first = 0;
            if (sp[31]) begin
                if (sp[29]) first = f; else lines = f;
            end
            chk("R1 bpp", bpp, bpp_of(code));
            chk("R3 pix_base", pix_base, topv + hdr_of(code, mode));
            chk("R9 stride", stride, ((wm1 + 1) * bpp_of(code)) / 8);
            chk("R8 line_cnt", line_cnt, lines);
            chk("R8 first_line", first_line, first);
            if (dual_mode) exp_buf = ~exp_buf;
        end
        chk("R7 cur_buf", cur_buf, exp_buf);
    endtask

    task automatic set_cur_bot(input longint v);
        if (exp_buf) buf1_bot = AW'(v); else buf0_bot = AW'(v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 reset enabled", lcd_enabled, 0);
        chk("R11 reset cur_buf", cur_buf, 0);
        chk("R11 reset pulses", {frame_valid, sync_err, addr_err, buf_done, done_irq}, 0);

        win_lo = 32'h1000; win_hi = 32'hF_FFFF;
        buf0_top = 32'h1000; buf0_bot = 32'hF_FFFF;
        buf1_top = 32'h0; buf1_bot = 32'h0;
        dual_mode = 0;
        run_frame(3, 0, 7, 7, 0, "R11 disabled ignore");
        do_enable(1);        // R10 window edges inclusive, buffer 1 unchecked
        do_enable(0);
        dual_mode = 1;
        do_enable(1);        // R10 buffer 1 out of window
        buf1_top = 32'h5_0000; buf1_bot = 32'h8_0000;
        buf0_top = 32'h1_0000; buf0_bot = 32'h4_0000;
        do_enable(1);
        done_irq_en = 1;
        run_frame(3, 0, 15, 7, 0, "R1");
        run_frame(1, 0, 31, 3, 0, "R3");
        done_irq_en = 0;
        run_frame(0, 0, 15, 7, 0, "R2");
        run_frame(5, 1, 15, 7, 0, "R4");
        run_frame(2, 2, 15, 7, 0, "R3");
        run_frame(4, 0, 9, 9, 32'hA005_0000, "R8");
        run_frame(6, 3, 9, 9, 32'h8003_0000, "R8");
        run_frame(7, 0, 9, 9, 32'h2007_0000, "R8");
        dual_mode = 0;
        set_cur_bot((exp_buf ? longint'(buf1_top) : longint'(buf0_top)) + need_of(4, 0, 15, 7) - 2);
        run_frame(4, 0, 15, 7, 0, "R5 equal fits");
        set_cur_bot((exp_buf ? longint'(buf1_top) : longint'(buf0_top)) + need_of(4, 0, 15, 7) - 3);
        run_frame(4, 0, 15, 7, 0, "R5 one over");
        run_frame(4, 0, 0, 0, 0, "R5 after sync off");

        for (int it = 0; it < 300; it++) begin
            int code, mode, wm1, hm1, sel, delta;
            logic [31:0] sp;
            buf0_top = 32'h2_0000 + ($urandom % 256) * 4;
            buf1_top = 32'h6_0000 + ($urandom % 256) * 4;
            buf0_bot = buf0_top + 32'h8000;
            buf1_bot = buf1_top + 32'h8000;
            dual_mode = $urandom % 2;
            if (!exp_en) do_enable(1);
            done_irq_en = $urandom % 2;
            code = $urandom % 8;
            mode = (($urandom % 8) == 0) ? 1 : (($urandom % 2) ? 0 : 2);
            wm1 = $urandom % 48;
            hm1 = $urandom % 48;
            sel = $urandom % 3;
            sp = (sel == 0) ? 32'h0 :
                 (sel == 1) ? (32'h8000_0000 | (($urandom % 64) << 16)) :
                              (32'hA000_0000 | (($urandom % 64) << 16));
            delta = int'($urandom % 9) - 4;
            set_cur_bot((exp_buf ? longint'(buf1_top) : longint'(buf0_top)) +
                        need_of(code, mode, wm1, hm1) - 2 + delta);
            run_frame(code, mode, wm1, hm1, sp, "R11 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule